// File: doc/BRIEF.md
# Sticky Maskable Interrupt Controller

This block collects event conditions from the rest of a device and reports them on one active-high interrupt line. Each condition input is synchronised to the block clock. A rising edge of a condition sets a sticky status bit. Conditions are grouped eight to a bank. Every bank has a status register, which is read-only, and a mask register, which is read/write. Each event has its own mask bit.

Software reads a status register to acknowledge the bits in that bank. A read clears a bit only when that bit's condition is absent at the time of the read. Every read acknowledges the bits it returns, so the interrupt line drops once all set, unmasked bits have been read, even when some bits stay set because their conditions are still present. After that, a condition that stays present cannot raise the line again. Only a new rising edge of that condition can.

The register port is a plain, single-cycle port. Read data is combinational from the addressed register. A read or write takes effect on the clock edge during which its strobe is high.

Top module: `irq_sticky_ctrl`

## Requirements
- R1: During and just after reset, all status bits read 0, all mask bits read 1 (masked), and `irq_o` is 0.
- R2: A rising edge on an unmasked condition sets its status bit. `irq_o` goes high by the third rising clock edge after the condition rises (two synchroniser stages plus edge detection), and it is still low after the second edge.
- R3: A rising edge on a masked condition sets its status bit and leaves `irq_o` unchanged.
- R4: A status bit stays set after its condition falls, until its register is read.
- R5: Reading a status register returns its bits. The read clears each bit whose synchronised condition is absent and leaves set each bit whose condition is present.
- R6: A read acknowledges every bit it returns. `irq_o` falls once every set unmasked bit has been read, even when those bits stay set. A condition that persists does not raise `irq_o` again; only a new rising edge of it does.
- R7: Reading one bank's status register acknowledges and clears nothing in any other bank.
- R8: Address map: status of bank b is at address b, and mask of bank b is at address NUM_BANKS+b. Bit i of bank b corresponds to `cond_i[8*b+i]`. A mask bit of 1 masks the event. Mask registers read back the last value written.
- R9: Clearing a mask bit whose status bit is set and unacknowledged raises `irq_o` on the write's clock edge. Setting that mask bit again stops it from holding `irq_o` high.
- R10: When a new rising edge of a condition lands in the same cycle as a read of its register, the bit stays set and unacknowledged, so `irq_o` stays high if the bit is unmasked.
- R11: Writes to status register addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | NUM_BANKS*8 | Event condition levels, asynchronous |
| addr_i | input | ADDR_W | Register address |
| rd_en_i | input | 1 | Read strobe; a read of a status register acknowledges that bank |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data from the addressed register, combinational |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that any condition pulse lasts long enough to pass the synchroniser, which means at least one clock period per stage. The bench drives every strobe and condition change on the falling clock edge. It uses one strobe at a time and holds each condition level for at least three clock cycles. It lines up the one same-cycle case (a rising edge that coincides with a read) by counting clock edges from the moment the condition changes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int unsigned BANK_W = 8;
  typedef logic [BANK_W-1:0] bank_t;

  // status update: new edges set, a read clears only bits whose condition is gone
  function automatic bank_t status_next(bank_t cur, bank_t rise, bank_t lvl, logic ack);
    bank_t kept;
    kept = ack ? (cur & lvl) : cur;
    return kept | rise;
  endfunction

  // unacknowledged flag: a read acknowledges everything except edges arriving now
  function automatic bank_t pend_next(bank_t cur, bank_t rise, logic ack);
    return (ack ? '0 : cur) | rise;
  endfunction

  // bits that currently demand the interrupt line
  function automatic bank_t live_bits(bank_t status, bank_t pend, bank_t mask);
    return status & pend & ~mask;
  endfunction

  function automatic logic is_status_addr(int unsigned a, int unsigned nb, int unsigned b);
    return a == b && b < nb;
  endfunction

  function automatic logic is_mask_addr(int unsigned a, int unsigned nb, int unsigned b);
    return a == nb + b;
  endfunction
endpackage

// File: rtl/irq_cond_sync.sv
module irq_cond_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cond_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], cond_i[i]};
    end
    assign lvl_o[i] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~prev_q;

  // R2: an edge pulse lasts a single cycle
  a_r2_rise_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  bank_t rise_i,
  input  bank_t lvl_i,
  input  logic  ack_i,
  input  logic  mask_we_i,
  input  bank_t mask_wdata_i,
  output bank_t status_o,
  output bank_t mask_o,
  output logic  req_o
);
  bank_t status_q, pend_q, mask_q;
  bank_t live_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      pend_q   <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= status_next(status_q, rise_i, lvl_i, ack_i);
      pend_q   <= pend_next(pend_q, rise_i, ack_i);
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign live_w   = live_bits(status_q, pend_q, mask_q);
  assign req_o    = |live_w;
  assign status_o = status_q;
  assign mask_o   = mask_q;

  // R2: an edge always lands in the status register
  a_r2_rise_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i != '0) |=> ((status_q & $past(rise_i)) == $past(rise_i)));
  // R10: an edge in a read cycle stays unacknowledged
  a_r10_rise_stays_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && rise_i != '0) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));
  // R4: nothing clears without a read
  a_r4_sticky_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R5: a present condition survives a read
  a_r5_present_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> ((status_q & $past(status_q & lvl_i)) == $past(status_q & lvl_i)));
  // R6: a read with no new edge acknowledges the whole bank
  a_r6_read_acknowledges: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && rise_i == '0) |=> (pend_q == '0));
  // R6: only set bits can be unacknowledged
  a_r6_pend_within_status: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~status_q) == '0));
  // R8: masks change only on a write
  a_r8_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_regport.sv
module irq_regport
  import irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        rd_en_i,
  input  logic                        wr_en_i,
  input  logic [NUM_BANKS*BANK_W-1:0] status_all_i,
  input  logic [NUM_BANKS*BANK_W-1:0] mask_all_i,
  output logic [NUM_BANKS-1:0]        ack_o,
  output logic [NUM_BANKS-1:0]        mask_we_o,
  output bank_t                       rd_data_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    assign ack_o[b]     = rd_en_i && is_status_addr(int'(addr_i), NUM_BANKS, b);
    assign mask_we_o[b] = wr_en_i && is_mask_addr(int'(addr_i), NUM_BANKS, b);
  end

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (is_status_addr(int'(addr_i), NUM_BANKS, b))
        rd_data_o = status_all_i[b*BANK_W +: BANK_W];
      if (is_mask_addr(int'(addr_i), NUM_BANKS, b))
        rd_data_o = mask_all_i[b*BANK_W +: BANK_W];
    end
  end

  // R7: at most one bank is acknowledged per cycle
  a_r7_single_bank_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));
  // R11: a write never acknowledges a status register
  a_r11_write_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !rd_en_i) |-> (ack_o == '0));
endmodule

// File: rtl/irq_sticky_ctrl.sv
module irq_sticky_ctrl
  import irq_pkg::*;
#(
  parameter  int unsigned NUM_BANKS   = 2,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_EV      = NUM_BANKS * BANK_W,
  localparam int unsigned ADDR_W      = $clog2(2 * NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] cond_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] wr_data_i,
  output logic [BANK_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [NUM_EV-1:0]    lvl_w, rise_w, status_all_w, mask_all_w;
  logic [NUM_BANKS-1:0] ack_w, mask_we_w, req_w;

  irq_cond_sync #(.WIDTH(NUM_EV), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .lvl_o(lvl_w), .rise_o(rise_w));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .rise_i(rise_w[b*BANK_W +: BANK_W]),
      .lvl_i(lvl_w[b*BANK_W +: BANK_W]),
      .ack_i(ack_w[b]),
      .mask_we_i(mask_we_w[b]),
      .mask_wdata_i(wr_data_i),
      .status_o(status_all_w[b*BANK_W +: BANK_W]),
      .mask_o(mask_all_w[b*BANK_W +: BANK_W]),
      .req_o(req_w[b]));
  end

  irq_regport #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .status_all_i(status_all_w), .mask_all_i(mask_all_w),
    .ack_o(ack_w), .mask_we_o(mask_we_w), .rd_data_o(rd_data_o));

  assign irq_o = |req_w;

  // R1: the line is quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) a_r1_quiet_in_reset: assert (irq_o == 1'b0);
  end
  // R3: with every mask set, the line cannot rise
  a_r3_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_all_w == '1) |-> !irq_o);
endmodule

// File: tb/irq_sticky_ctrl_test.sv
`timescale 1ns/1ps
module irq_sticky_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cond = '0;
  logic [1:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_sticky_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond), .addr_i(addr), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_irq(string req, logic exp);
    check(req, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic rd(logic [1:0] a, string req, logic [7:0] exp);
    addr = a; rd_en = 1'b1; #1;
    check(req, rdata, exp);
    tick(1); rd_en = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick(1); wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk_irq("R1", 1'b0);
    rd(2, "R1", 8'hFF); rd(3, "R1", 8'hFF);
    rd(0, "R1", 8'h00); rd(1, "R1", 8'h00);
  endtask

  task automatic t_mask_rw;
    wr(2, 8'h5A); wr(3, 8'hC3);
    rd(2, "R8", 8'h5A); rd(3, "R8", 8'hC3);
    wr(2, 8'h00); wr(3, 8'hFF);
    rd(2, "R8", 8'h00);
  endtask

  task automatic t_unmasked;
    cond[0] = 1'b1; tick(2);
    chk_irq("R2", 1'b0);
    tick(1); chk_irq("R2", 1'b1);
    rd(0, "R5", 8'h01); chk_irq("R6", 1'b0);
    rd(0, "R5", 8'h01);
    cond[0] = 1'b0; tick(3);
    chk_irq("R4", 1'b0);
    rd(0, "R4", 8'h01); rd(0, "R5", 8'h00);
  endtask

  task automatic t_masked;
    cond[8] = 1'b1; tick(3);
    chk_irq("R3", 1'b0);
    wr(3, 8'hFE); chk_irq("R9", 1'b1);
    wr(3, 8'hFF); chk_irq("R9", 1'b0);
    wr(3, 8'hFE); chk_irq("R9", 1'b1);
    rd(0, "R7", 8'h00); chk_irq("R7", 1'b1);
    cond[8] = 1'b0; tick(3);
    rd(1, "R7", 8'h01); chk_irq("R6", 1'b0);
    rd(1, "R5", 8'h00);
    wr(3, 8'hFF);
  endtask

  task automatic t_status_write;
    cond[1] = 1'b1; tick(3); cond[1] = 1'b0; tick(3);
    wr(0, 8'h00); wr(1, 8'hFF);
    chk_irq("R11", 1'b1);
    rd(1, "R11", 8'h00);
    rd(0, "R11", 8'h02); rd(0, "R11", 8'h00);
  endtask

  task automatic t_persist;
    cond[2] = 1'b1; tick(3); chk_irq("R6", 1'b1);
    rd(0, "R6", 8'h04); tick(10);
    chk_irq("R6", 1'b0);
    cond[2] = 1'b0; tick(3);
    cond[2] = 1'b1; tick(3);
    chk_irq("R6", 1'b1);
    rd(0, "R6", 8'h04);
    cond[2] = 1'b0; tick(3);
    rd(0, "R5", 8'h04); rd(0, "R5", 8'h00);
  endtask

  task automatic t_coincide;
    cond[3] = 1'b1; tick(3);
    rd(0, "R10", 8'h08);
    cond[3] = 1'b0; tick(3);
    chk_irq("R10", 1'b0);
    cond[3] = 1'b1; tick(2);
    rd(0, "R10", 8'h08);
    chk_irq("R10", 1'b1);
    rd(0, "R10", 8'h08); chk_irq("R10", 1'b0);
    cond[3] = 1'b0; tick(3);
    rd(0, "R5", 8'h08); rd(0, "R5", 8'h00);
  endtask

  task automatic t_multi;
    cond[5] = 1'b1; cond[7] = 1'b1; tick(3);
    cond[5] = 1'b0; tick(3);
    rd(0, "R5", 8'hA0); rd(0, "R5", 8'h80);
    chk_irq("R6", 1'b0);
    cond[7] = 1'b0; tick(3);
    rd(0, "R5", 8'h80); rd(0, "R5", 8'h00);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    t_reset();
    t_mask_rw();
    t_unmasked();
    t_masked();
    t_status_write();
    t_persist();
    t_coincide();
    t_multi();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule